// File: doc/BRIEF.md
# Sprite Scene Framebuffer Painter

This block keeps the state of a small two-sprite game and repaints the whole scene into an external pixel framebuffer once per video frame. It owns a plain write port (address, colour data, write strobe). The framebuffer memory and the video timing are outside the block. The video timing supplies two signals. A grant input is high only while the display is blanked and the memory may be written. A vertical-blank level marks the start of each frame.

On every rising edge of the vertical-blank level, both sprite positions advance by one step. The enemy is a solid rectangle that patrols the ground on its own. The player is a solid rectangle that climbs diagonally up and to the right while a debounced push button is held. One cycle later a painting pass begins, using the positions as they stood at that moment. The pass fills the sky, then the ground band, then the enemy, then the player, each rectangle scanned row by row.

The grant acts as the only back-pressure on the write port. A write takes place in every cycle where the strobe is high, and the memory cannot refuse it. The block therefore raises the strobe only while the grant is high. When the grant falls, the painter freezes with its address and data unchanged, and it resumes from the same pixel when the grant returns. All logic runs on one pixel clock.

Top module: `sprite_scene_painter`

## Requirements
- R1: The write strobe is never high in a cycle where the grant input is low. While a pass is paused by a low grant, the address and data outputs hold their values, and the first write after the grant returns uses that held address, so no pixel is lost or repeated.
- R2: A frame tick is the rising edge of the vertical-blank input. Holding that input high does not produce more ticks. Each tick starts exactly one pass of SCR_W*SCR_H + SCR_W*GND + 2*SPR*SPR writes, the first write coming no earlier than two cycles after the edge.
- R3: A pass writes four rectangles in a fixed order: the full screen in SKY_COL, the bottom GND rows in GND_COL, the enemy in ENEMY_COL, and the player in PLAYER_COL. After the pass, each pixel shows the colour of the last rectangle that covers it (player over enemy over ground over sky). A pixel at column x and row y lives at address y*SCR_W + x.
- R4: The enemy is SPR by SPR pixels. Its top row is SCR_H-GND-SPR. It starts at x = 0 moving right and steps one pixel per frame tick. It turns around on reaching x = SCR_W-SPR and on reaching x = 0, so x never leaves that range.
- R5: The player is SPR by SPR pixels and starts at x = 0, y = SCR_H-GND-SPR. On a frame tick with the debounced button pressed, x rises by one, saturating at SCR_W-SPR, and y falls by one, saturating at 0. Without a press, the position is unchanged.
- R6: The button passes through a two-flop synchroniser and a debounce counter. A new level takes effect only after it has been seen for DEB_CYC consecutive cycles, and a shorter pulse has no effect on the player.
- R7: In reset and after it, no write occurs until the first frame tick. The sprites start at the positions given in R4 and R5.
- R8: The pass paints the positions latched when it started, even if the grant pauses it for many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, the only clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_i | input | 1 | High while the framebuffer may be written (blanking) |
| vblank_i | input | 1 | Vertical-blank level from the video timing |
| button_i | input | 1 | Raw push button, asynchronous, active high |
| wr_en_o | output | 1 | Framebuffer write strobe |
| wr_addr_o | output | $clog2(SCR_W*SCR_H) | Pixel address, row-major |
| wr_data_o | output | PIX_W | Pixel colour |

## Verification
Several behaviours are checked on every cycle inside the RTL:
- the write strobe stays low without the grant, and address and phase stay frozen during a paused pass;
- every address falls inside the screen;
- the enemy moves exactly one pixel per tick and stays in range, and the player moves only on a pressed tick and stays in bounds;
- the debounced level changes only when its counter expires.

Other behaviours can be shown only by the bench's scenarios, each comparing a full model framebuffer against the one the block paints:
- the painting order and the overlap priority;
- the exact write count per tick while vertical blank is held;
- rejection of a short button glitch;
- saturation of the player in the top-right corner;
- the enemy's turn at the right edge.

// File: rtl/sprite_scene_pkg.sv
package sprite_scene_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SKY    = 3'd1,
    PH_GROUND = 3'd2,
    PH_ENEMY  = 3'd3,
    PH_PLAYER = 3'd4
  } phase_t;
endpackage

// File: rtl/button_conditioner.sv
module button_conditioner #(
  parameter int DEB_CYC = 270000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic pressed_o
);
  localparam int CW = $clog2(DEB_CYC + 1);

  logic          sync_a, sync_b;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a    <= 1'b0;
      sync_b    <= 1'b0;
      cnt       <= '0;
      pressed_o <= 1'b0;
    end else begin
      sync_a <= raw_i;
      sync_b <= sync_a;
      if (sync_b == pressed_o) begin
        cnt <= '0;
      end else if (cnt == CW'(DEB_CYC - 1)) begin
        cnt       <= '0;
        pressed_o <= sync_b;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: the clean level only moves once the counter has run out
  assert_deb_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pressed_o != $past(pressed_o)) |-> ($past(cnt) == CW'(DEB_CYC - 1)));
endmodule

// File: rtl/sprite_motion.sv
module sprite_motion #(
  parameter int SCR_W = 640,
  parameter int SCR_H = 480,
  parameter int SPR   = 16,
  parameter int GND   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_i,
  input  logic                      pressed_i,
  output logic [$clog2(SCR_W)-1:0]  enemy_x_o,
  output logic [$clog2(SCR_W)-1:0]  player_x_o,
  output logic [$clog2(SCR_H)-1:0]  player_y_o
);
  localparam int XW = $clog2(SCR_W);
  localparam int YW = $clog2(SCR_H);
  localparam logic [XW-1:0] X_LIM = XW'(SCR_W - SPR);
  localparam logic [YW-1:0] Y_GND = YW'(SCR_H - GND - SPR);

  logic heading_right;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enemy_x_o     <= '0;
      heading_right <= 1'b1;
      player_x_o    <= '0;
      player_y_o    <= Y_GND;
    end else if (tick_i) begin
      if (heading_right) begin
        enemy_x_o <= enemy_x_o + 1'b1;
        if (enemy_x_o == X_LIM - 1'b1) heading_right <= 1'b0;
      end else begin
        enemy_x_o <= enemy_x_o - 1'b1;
        if (enemy_x_o == XW'(1)) heading_right <= 1'b1;
      end
      if (pressed_i) begin
        if (player_x_o != X_LIM) player_x_o <= player_x_o + 1'b1;
        if (player_y_o != '0)    player_y_o <= player_y_o - 1'b1;
      end
    end
  end

  // R4: patrol stays on screen and moves exactly one pixel per tick
  assert_enemy_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enemy_x_o <= X_LIM);
  assert_enemy_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (enemy_x_o == $past(enemy_x_o) + 1'b1) || (enemy_x_o == $past(enemy_x_o) - 1'b1));
  // R5: player only moves on a pressed tick, and stays inside its bounds
  assert_player_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_i && pressed_i) |=> $stable(player_x_o) && $stable(player_y_o));
  assert_player_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (player_x_o <= X_LIM) && (player_y_o <= Y_GND));
endmodule

// File: rtl/scene_rasterizer.sv
module scene_rasterizer
  import sprite_scene_pkg::*;
#(
  parameter int SCR_W = 640,
  parameter int SCR_H = 480,
  parameter int SPR   = 16,
  parameter int GND   = 32,
  parameter int PIX_W = 12,
  parameter logic [PIX_W-1:0] SKY_COL    = 12'h6BF,
  parameter logic [PIX_W-1:0] GND_COL    = 12'h842,
  parameter logic [PIX_W-1:0] ENEMY_COL  = 12'hC60,
  parameter logic [PIX_W-1:0] PLAYER_COL = 12'hF00
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  input  logic                            grant_i,
  input  logic [$clog2(SCR_W)-1:0]        enemy_x_i,
  input  logic [$clog2(SCR_W)-1:0]        player_x_i,
  input  logic [$clog2(SCR_H)-1:0]        player_y_i,
  output logic                            wr_en_o,
  output logic [$clog2(SCR_W*SCR_H)-1:0]  wr_addr_o,
  output logic [PIX_W-1:0]                wr_data_o
);
  localparam int XW = $clog2(SCR_W);
  localparam int YW = $clog2(SCR_H);
  localparam int AW = $clog2(SCR_W * SCR_H);
  localparam logic [YW-1:0] ENEMY_Y = YW'(SCR_H - GND - SPR);

  phase_t        phase;
  logic [XW-1:0] cx, ex_l, px_l, ox, last_x;
  logic [YW-1:0] cy, py_l, oy, last_y;
  logic [XW-1:0] abs_x;
  logic [YW-1:0] abs_y;
  logic          busy, row_end, rect_end;

  always_comb begin
    ox = '0; oy = '0; last_x = '0; last_y = '0; wr_data_o = '0;
    case (phase)
      PH_SKY:    begin last_x = XW'(SCR_W - 1); last_y = YW'(SCR_H - 1);
                       wr_data_o = SKY_COL; end
      PH_GROUND: begin oy = YW'(SCR_H - GND); last_x = XW'(SCR_W - 1);
                       last_y = YW'(GND - 1); wr_data_o = GND_COL; end
      PH_ENEMY:  begin ox = ex_l; oy = ENEMY_Y; last_x = XW'(SPR - 1);
                       last_y = YW'(SPR - 1); wr_data_o = ENEMY_COL; end
      PH_PLAYER: begin ox = px_l; oy = py_l; last_x = XW'(SPR - 1);
                       last_y = YW'(SPR - 1); wr_data_o = PLAYER_COL; end
      default:   ;
    endcase
  end

  assign busy      = (phase != PH_IDLE);
  assign wr_en_o   = busy & grant_i;
  assign abs_x     = ox + cx;
  assign abs_y     = oy + cy;
  assign wr_addr_o = AW'(abs_y) * AW'(SCR_W) + AW'(abs_x);
  assign row_end   = (cx == last_x);
  assign rect_end  = row_end && (cy == last_y);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cx    <= '0;
      cy    <= '0;
      ex_l  <= '0;
      px_l  <= '0;
      py_l  <= '0;
    end else if (!busy) begin
      if (start_i) begin
        phase <= PH_SKY;
        cx    <= '0;
        cy    <= '0;
        ex_l  <= enemy_x_i;
        px_l  <= player_x_i;
        py_l  <= player_y_i;
      end
    end else if (wr_en_o) begin
      if (row_end) begin
        cx <= '0;
        cy <= cy + 1'b1;
        if (rect_end) begin
          cy <= '0;
          case (phase)
            PH_SKY:    phase <= PH_GROUND;
            PH_GROUND: phase <= PH_ENEMY;
            PH_ENEMY:  phase <= PH_PLAYER;
            default:   phase <= PH_IDLE;
          endcase
        end
      end else begin
        cx <= cx + 1'b1;
      end
    end
  end

  // R1: a paused pass keeps its place exactly
  assert_pause_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !grant_i) |=> $stable(wr_addr_o) && $stable(phase) && $stable(wr_data_o));
  // R3: every address written lies on the screen
  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_addr_o < AW'(SCR_W * SCR_H)));
  // R8: latched sprite positions do not move during a pass
  assert_latch_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ex_l) && $stable(px_l) && $stable(py_l));
endmodule

// File: rtl/sprite_scene_painter.sv
module sprite_scene_painter #(
  parameter int SCR_W   = 640,
  parameter int SCR_H   = 480,
  parameter int SPR     = 16,
  parameter int GND     = 32,
  parameter int DEB_CYC = 270000,
  parameter int PIX_W   = 12,
  parameter logic [PIX_W-1:0] SKY_COL    = 12'h6BF,
  parameter logic [PIX_W-1:0] GND_COL    = 12'h842,
  parameter logic [PIX_W-1:0] ENEMY_COL  = 12'hC60,
  parameter logic [PIX_W-1:0] PLAYER_COL = 12'hF00
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            grant_i,
  input  logic                            vblank_i,
  input  logic                            button_i,
  output logic                            wr_en_o,
  output logic [$clog2(SCR_W*SCR_H)-1:0]  wr_addr_o,
  output logic [PIX_W-1:0]                wr_data_o
);
  localparam int XW = $clog2(SCR_W);
  localparam int YW = $clog2(SCR_H);

  logic          vb_q, tick, start_q, pressed;
  logic [XW-1:0] enemy_x, player_x;
  logic [YW-1:0] player_y;

  assign tick = vblank_i & ~vb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vb_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      vb_q    <= vblank_i;
      start_q <= tick;
    end
  end

  button_conditioner #(.DEB_CYC(DEB_CYC)) btn_u (
    .clk(clk), .rst_n(rst_n), .raw_i(button_i), .pressed_o(pressed));

  sprite_motion #(.SCR_W(SCR_W), .SCR_H(SCR_H), .SPR(SPR), .GND(GND)) motion_u (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .pressed_i(pressed),
    .enemy_x_o(enemy_x), .player_x_o(player_x), .player_y_o(player_y));

  scene_rasterizer #(
    .SCR_W(SCR_W), .SCR_H(SCR_H), .SPR(SPR), .GND(GND), .PIX_W(PIX_W),
    .SKY_COL(SKY_COL), .GND_COL(GND_COL), .ENEMY_COL(ENEMY_COL), .PLAYER_COL(PLAYER_COL)
  ) raster_u (
    .clk(clk), .rst_n(rst_n), .start_i(start_q), .grant_i(grant_i),
    .enemy_x_i(enemy_x), .player_x_i(player_x), .player_y_i(player_y),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o));

  // R1: no write without the grant, seen at the ports
  assert_grant_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_i |-> !wr_en_o);
  // R2: no write in the cycle right after a tick
  assert_tick_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en_o) |=> !wr_en_o);
endmodule

// File: tb/sprite_scene_painter_tb_top.sv
module sprite_scene_painter_tb_top;
  localparam int W = 32, H = 24, S = 4, G = 4, DEB = 8, PW = 12;
  localparam int AW = $clog2(W * H);
  localparam int EXP_WR = W * H + W * G + 2 * S * S;
  localparam int EY = H - G - S;
  localparam int XL = W - S;
  localparam logic [PW-1:0] C_SKY = 12'h6BF, C_GND = 12'h842,
                            C_EN = 12'hC60, C_PL = 12'hF00;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, grant, vblank, button;
  logic wr_en;
  logic [AW-1:0] wr_addr;
  logic [PW-1:0] wr_data;

  sprite_scene_painter #(.SCR_W(W), .SCR_H(H), .SPR(S), .GND(G), .DEB_CYC(DEB),
    .PIX_W(PW), .SKY_COL(C_SKY), .GND_COL(C_GND), .ENEMY_COL(C_EN), .PLAYER_COL(C_PL))
  dut_i (.clk(clk), .rst_n(rst_n), .grant_i(grant), .vblank_i(vblank),
    .button_i(button), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data));

  int checks = 0, errors = 0;
  int grant_mode = 0, gcnt = 0;
  int wcount = 0, gate_err = 0, hold_err = 0;
  bit in_pass = 0, prev_grant = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [PW-1:0] fb [W*H];
  int m_ex = 0, m_px = 0, m_py = EY;
  bit m_right = 1, m_pressed = 0;

  always @(posedge clk) begin
    #1;
    gcnt++;
    case (grant_mode)
      0: grant = 1'b1;
      1: grant = ((gcnt % 8) >= 3);
      default: grant = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (!grant) gate_err++;
        if (int'(wr_addr) < W * H) fb[wr_addr] = wr_data; else gate_err++;
        if (in_pass && !prev_grant && wcount > 0 && wr_addr != prev_addr) hold_err++;
        wcount++;
      end else if (in_pass && !grant && !prev_grant && wcount > 0 && wcount < EXP_WR
                   && wr_addr != prev_addr) begin
        hold_err++;
      end
      prev_grant = grant;
      prev_addr  = wr_addr;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] exp_pix(int x, int y);
    if (x >= m_px && x < m_px + S && y >= m_py && y < m_py + S) return C_PL;
    if (x >= m_ex && x < m_ex + S && y >= EY && y < EY + S) return C_EN;
    if (y >= H - G) return C_GND;
    return C_SKY;
  endfunction

  task automatic model_tick();
    if (m_right) begin m_ex++; if (m_ex == XL) m_right = 0; end
    else begin m_ex--; if (m_ex == 0) m_right = 1; end
    if (m_pressed) begin
      if (m_px < XL) m_px++;
      if (m_py > 0) m_py--;
    end
  endtask

  task automatic run_frame(int mode, int vb_len, string req);
    int t = 0;
    int bad = 0;
    int first = -1;
    wcount = 0; in_pass = 1; grant_mode = mode;
    @(posedge clk); #2;
    vblank = 1'b1;
    repeat (vb_len) @(posedge clk);
    #2 vblank = 1'b0;
    model_tick();
    while (wcount < EXP_WR && t < 8000) begin @(posedge clk); t++; end
    repeat (40) @(posedge clk);
    in_pass = 0;
    check(wcount == EXP_WR, req, "write count per tick", wcount, EXP_WR);
    for (int i = 0; i < W * H; i++)
      if (fb[i] !== exp_pix(i % W, i / W)) begin bad++; if (first < 0) first = i; end
    check(bad == 0, req, "mismatching pixels (first index in message)", bad, 0);
    if (bad != 0) $display("  first mismatch at address %0d", first);
  endtask

  task automatic t_reset();
    check(wr_en == 1'b0, "R7", "strobe after reset", int'(wr_en), 0);
    repeat (50) @(posedge clk);
    check(wcount == 0, "R7", "writes before first tick", wcount, 0);
  endtask

  task automatic t_first_frame();
    run_frame(0, 1, "R3");
    // R3 overlap: player at x 0..3 covers enemy at x 1..4 on row EY
    check(fb[EY*W+1] == C_PL, "R3", "overlap pixel colour", int'(fb[EY*W+1]), int'(C_PL));
    check(fb[EY*W+4] == C_EN, "R3", "enemy edge colour", int'(fb[EY*W+4]), int'(C_EN));
    check(fb[(H-1)*W] == C_GND, "R3", "ground pixel", int'(fb[(H-1)*W]), int'(C_GND));
  endtask

  task automatic t_paused_grant();
    run_frame(1, 1, "R8");
    check(gate_err == 0, "R1", "writes without grant", gate_err, 0);
    check(hold_err == 0, "R1", "address moved during pause", hold_err, 0);
  endtask

  task automatic t_long_vblank();
    run_frame(0, 40, "R2");
    repeat (200) @(posedge clk);
    check(wcount == EXP_WR, "R2", "no retrigger while vblank held", wcount, EXP_WR);
  endtask

  task automatic t_glitch();
    @(posedge clk); #2 button = 1'b1;
    repeat (2) @(posedge clk);
    #2 button = 1'b0;
    repeat (20) @(posedge clk);
    run_frame(0, 1, "R6");
    check(fb[EY*W] == C_PL, "R6", "player still at start after glitch", int'(fb[EY*W]), int'(C_PL));
  endtask

  task automatic t_climb();
    @(posedge clk); #2 button = 1'b1;
    repeat (DEB + 10) @(posedge clk);
    m_pressed = 1;
    for (int f = 0; f < 30; f++) run_frame(0, 1, "R5");
    check(fb[XL] == C_PL, "R5", "player saturated top-right", int'(fb[XL]), int'(C_PL));
    check(fb[XL-1] == C_SKY, "R5", "left of saturated player", int'(fb[XL-1]), int'(C_SKY));
    // R4: enemy reached the right edge and has come back to x = 22
    check(fb[EY*W+22] == C_EN, "R4", "enemy after turn", int'(fb[EY*W+22]), int'(C_EN));
    check(fb[EY*W+26] == C_SKY, "R4", "right of turned enemy", int'(fb[EY*W+26]), int'(C_SKY));
    #2 button = 1'b0;
    repeat (DEB + 10) @(posedge clk);
    m_pressed = 0;
    run_frame(1, 1, "R5");
    check(fb[XL] == C_PL, "R5", "player holds after release", int'(fb[XL]), int'(C_PL));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vblank = 1'b0; button = 1'b0; grant = 1'b1;
    for (int i = 0; i < W * H; i++) fb[i] = '0;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_first_frame();
    t_paused_grant();
    t_long_vblank();
    t_glitch();
    t_climb();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule